// File: doc/BRIEF.md
# Register Rename Stage with Free List

This block sits at the end of the front end and translates the architectural register numbers of one instruction per cycle into physical register tags. Both source operands are looked up in a rename table. The destination is given a new physical register from the head of a circular free list, and the table entry for that destination is then redirected to it. Because every write gets a new physical register, later pipeline stages see only physical tags, and write-after-read and write-after-write conflicts between instructions cannot occur.

A ready bit is kept for each physical register. Allocation clears it, and a writeback port sets it again, so the scheduler can tell whether each source value already exists. The prior mapping of the destination is returned with every renamed instruction so that commit logic can release it later through the free port. When no physical register is free, the stage stalls the incoming instruction and changes no state.

Top module: `rn_rename_stage`

## Requirements
- R1: `src1_tag_o`/`src2_tag_o` equal the rename-table entries of `src1_i`/`src2_i` as they stand before the current instruction's update, so a source equal to the destination gets the old tag.
- R2: An accepted instruction's `dst_tag_o` is the free-list head, and the next accepted instruction receives the following entry.
- R3: After an accepted instruction, the table entry of `dst_i` holds `dst_tag_o`, and `old_tag_o` carries the entry it held before.
- R4: After reset, architectural register k maps to physical register k, the free list holds ARCH_REGS up to PHYS_REGS-1 in ascending order, and ready bits are 1 for tags below ARCH_REGS and 0 above.
- R5: `src1_rdy_o`/`src2_rdy_o` report the stored ready bit of each source tag. Allocation clears the bit of the new tag from the next cycle on. A `wb_valid_i` pulse sets the bit of `wb_tag_i` from the next cycle on, with no same-cycle bypass.
- R6: A tag returned through `free_valid_i`/`free_tag_i` is appended at the tail and is handed out only after every tag that was already in the list.
- R7: With `in_valid_i` high and the free list empty, `stall_o` is 1, `out_valid_o` is 0, and neither the table nor the free list changes.
- R8: A release in the same cycle as an allocation takes effect together with it. A release in a cycle that stalls on an empty list does not lift that stall, and the tag is available from the next cycle.
- R9: With `in_valid_i` low, `out_valid_o` and `stall_o` are 0 and no mapping changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Instruction present |
| src1_i | input | AW | First source architectural register |
| src2_i | input | AW | Second source architectural register |
| dst_i | input | AW | Destination architectural register |
| stall_o | output | 1 | Instruction held: free list empty |
| out_valid_o | output | 1 | Instruction renamed this cycle |
| src1_tag_o | output | TW | Physical tag of first source |
| src1_rdy_o | output | 1 | Ready bit of first source tag |
| src2_tag_o | output | TW | Physical tag of second source |
| src2_rdy_o | output | 1 | Ready bit of second source tag |
| dst_tag_o | output | TW | New physical tag of destination |
| old_tag_o | output | TW | Prior mapping of destination |
| wb_valid_i | input | 1 | Result written for `wb_tag_i` |
| wb_tag_i | input | TW | Physical tag becoming ready |
| free_valid_i | input | 1 | Release a physical tag |
| free_tag_i | input | TW | Tag returned to the free list |

## Verification
The bench builds the stage with 8 architectural and 12 physical registers, so only four tags are free after reset. That small pool lets four instructions drain the list, which brings the empty-list stall, a release colliding with a stall, and a release during allocation within a few cycles. It also makes tags come back around through the tail, so FIFO order after recycling can be checked. The narrow tags keep every expected mapping short enough to work out by hand in the vector table.

// File: rtl/rn_pkg.sv
package rn_pkg;
    // Index width that never collapses to zero bits.
    function automatic int unsigned idx_w(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list
    import rn_pkg::*;
#(
    parameter int unsigned ARCH_REGS = 32,
    parameter int unsigned PHYS_REGS = 64,
    parameter int unsigned TW        = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop_i,
    input  logic          push_i,
    input  logic [TW-1:0] push_tag_i,
    output logic [TW-1:0] head_tag_o,
    output logic          empty_o,
    output logic [$clog2(PHYS_REGS-ARCH_REGS+1)-1:0] count_o
);
    localparam int unsigned DEPTH = PHYS_REGS - ARCH_REGS;
    localparam int unsigned PW    = idx_w(DEPTH);
    localparam int unsigned CW    = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][TW-1:0] slot;
        logic [PW-1:0]            head;
        logic [PW-1:0]            tail;
        logic [CW-1:0]            cnt;
    } fl_state_t;

    fl_state_t st_d, st_q;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign head_tag_o = st_q.slot[st_q.head];
    assign empty_o    = (st_q.cnt == '0);
    assign count_o    = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.slot[st_q.tail] = push_tag_i;
            st_d.tail            = wrap_inc(st_q.tail);
        end
        if (pop_i) begin
            st_d.head = wrap_inc(st_q.head);
        end
        st_d.cnt = st_q.cnt + CW'(push_i) - CW'(pop_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < int'(DEPTH); k++) begin
                st_q.slot[k] <= TW'(ARCH_REGS + k);
            end
            st_q.head <= '0;
            st_q.tail <= '0;
            st_q.cnt  <= CW'(DEPTH);
        end else begin
            st_q <= st_d;
        end
    end

    // R7: the stage must never take a tag from an empty list
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (st_q.cnt != '0));

    // R6: a release may not overrun a full list
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |-> (st_q.cnt < CW'(DEPTH)));

    // R6: a released tag lands at the old tail position
    p_push_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (st_q.slot[$past(st_q.tail)] == $past(push_tag_i)));
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table
    import rn_pkg::*;
#(
    parameter int unsigned ARCH_REGS = 32,
    parameter int unsigned TW        = 6,
    parameter int unsigned NRD       = 3
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic [NRD-1:0][idx_w(ARCH_REGS)-1:0]     rd_idx_i,
    output logic [NRD-1:0][TW-1:0]                   rd_tag_o,
    input  logic                                     wr_en_i,
    input  logic [idx_w(ARCH_REGS)-1:0]              wr_idx_i,
    input  logic [TW-1:0]                            wr_tag_i
);
    typedef struct packed {
        logic [ARCH_REGS-1:0][TW-1:0] map;
    } map_state_t;

    map_state_t st_d, st_q;

    // Reads see the table before this cycle's write.
    for (genvar g = 0; g < int'(NRD); g++) begin : g_rd
        assign rd_tag_o[g] = st_q.map[rd_idx_i[g]];
    end

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.map[wr_idx_i] = wr_tag_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < int'(ARCH_REGS); k++) begin
                st_q.map[k] <= TW'(k);
            end
        end else begin
            st_q <= st_d;
        end
    end

    // R3: an accepted write is visible in the next cycle
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (st_q.map[$past(wr_idx_i)] == $past(wr_tag_i)));

    // R9: without a write the table holds
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(st_q.map));
endmodule

// File: rtl/rn_ready_bits.sv
module rn_ready_bits #(
    parameter int unsigned ARCH_REGS = 32,
    parameter int unsigned PHYS_REGS = 64,
    parameter int unsigned TW        = 6,
    parameter int unsigned NRD       = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_en_i,
    input  logic [TW-1:0]           clr_tag_i,
    input  logic                    set_en_i,
    input  logic [TW-1:0]           set_tag_i,
    input  logic [NRD-1:0][TW-1:0]  rd_tag_i,
    output logic [NRD-1:0]          rd_rdy_o
);
    typedef struct packed {
        logic [PHYS_REGS-1:0] rdy;
    } rdy_state_t;

    rdy_state_t st_d, st_q;

    for (genvar g = 0; g < int'(NRD); g++) begin : g_rd
        assign rd_rdy_o[g] = st_q.rdy[rd_tag_i[g]];
    end

    // Allocation wins over a writeback to the same tag.
    always_comb begin
        st_d = st_q;
        if (set_en_i) st_d.rdy[set_tag_i] = 1'b1;
        if (clr_en_i) st_d.rdy[clr_tag_i] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < int'(PHYS_REGS); k++) begin
                st_q.rdy[k] <= (k < int'(ARCH_REGS));
            end
        end else begin
            st_q <= st_d;
        end
    end

    // R5: a newly allocated tag reads as not ready
    p_alloc_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> !st_q.rdy[$past(clr_tag_i)]);

    // R5: a writeback marks its tag ready
    p_wb_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en_i && !(clr_en_i && clr_tag_i == set_tag_i)) |=> st_q.rdy[$past(set_tag_i)]);
endmodule

// File: rtl/rn_rename_stage.sv
module rn_rename_stage
    import rn_pkg::*;
#(
    parameter int unsigned ARCH_REGS = 32,
    parameter int unsigned PHYS_REGS = 64,
    localparam int unsigned AW = idx_w(ARCH_REGS),
    localparam int unsigned TW = idx_w(PHYS_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid_i,
    input  logic [AW-1:0] src1_i,
    input  logic [AW-1:0] src2_i,
    input  logic [AW-1:0] dst_i,
    output logic          stall_o,
    output logic          out_valid_o,
    output logic [TW-1:0] src1_tag_o,
    output logic          src1_rdy_o,
    output logic [TW-1:0] src2_tag_o,
    output logic          src2_rdy_o,
    output logic [TW-1:0] dst_tag_o,
    output logic [TW-1:0] old_tag_o,
    input  logic          wb_valid_i,
    input  logic [TW-1:0] wb_tag_i,
    input  logic          free_valid_i,
    input  logic [TW-1:0] free_tag_i
);
    localparam int unsigned CW = $clog2(PHYS_REGS - ARCH_REGS + 1);

    logic                 fl_empty;
    logic [TW-1:0]        fl_head;
    logic [CW-1:0]        fl_count;
    logic                 accept;
    logic [2:0][AW-1:0]   map_rd_idx;
    logic [2:0][TW-1:0]   map_rd_tag;
    logic [1:0][TW-1:0]   rdy_rd_tag;
    logic [1:0]           rdy_rd;

    assign accept      = in_valid_i && !fl_empty;
    assign stall_o     = in_valid_i && fl_empty;
    assign out_valid_o = accept;

    assign map_rd_idx = {dst_i, src2_i, src1_i};
    assign src1_tag_o = map_rd_tag[0];
    assign src2_tag_o = map_rd_tag[1];
    assign old_tag_o  = map_rd_tag[2];
    assign dst_tag_o  = fl_head;

    assign rdy_rd_tag = {map_rd_tag[1], map_rd_tag[0]};
    assign src1_rdy_o = rdy_rd[0];
    assign src2_rdy_o = rdy_rd[1];

    rn_map_table #(
        .ARCH_REGS (ARCH_REGS),
        .TW        (TW),
        .NRD       (3)
    ) i_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx_i (map_rd_idx),
        .rd_tag_o (map_rd_tag),
        .wr_en_i  (accept),
        .wr_idx_i (dst_i),
        .wr_tag_i (fl_head)
    );

    rn_free_list #(
        .ARCH_REGS (ARCH_REGS),
        .PHYS_REGS (PHYS_REGS),
        .TW        (TW)
    ) i_free (
        .clk        (clk),
        .rst_n      (rst_n),
        .pop_i      (accept),
        .push_i     (free_valid_i),
        .push_tag_i (free_tag_i),
        .head_tag_o (fl_head),
        .empty_o    (fl_empty),
        .count_o    (fl_count)
    );

    rn_ready_bits #(
        .ARCH_REGS (ARCH_REGS),
        .PHYS_REGS (PHYS_REGS),
        .TW        (TW),
        .NRD       (2)
    ) i_rdy (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_en_i  (accept),
        .clr_tag_i (fl_head),
        .set_en_i  (wb_valid_i),
        .set_tag_i (wb_tag_i),
        .rd_tag_i  (rdy_rd_tag),
        .rd_rdy_o  (rdy_rd)
    );

    // R7: a stalled cycle without a release leaves the list untouched
    p_stall_holds_list_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && !free_valid_i) |=> $stable(fl_count));

    // R2: each accepted instruction without a release consumes one entry
    p_alloc_consumes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !free_valid_i) |=> (fl_count == $past(fl_count) - CW'(1)));

    // R8: release and allocation together leave the count level
    p_swap_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && free_valid_i) |=> (fl_count == $past(fl_count)));
endmodule

// File: tb/test_rn_rename_stage.sv
`timescale 1ns/1ps
module test_rn_rename_stage;
    localparam int unsigned ARCH = 8;
    localparam int unsigned PHYS = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] src1 = '0, src2 = '0, dst = '0;
    logic       stall, out_valid, r1, r2;
    logic [3:0] t1, t2, td, told;
    logic       wb_valid = 1'b0;
    logic [3:0] wb_tag = '0;
    logic       free_valid = 1'b0;
    logic [3:0] free_tag = '0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    rn_rename_stage #(.ARCH_REGS(ARCH), .PHYS_REGS(PHYS)) i_rn_rename_stage (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid),
        .src1_i(src1), .src2_i(src2), .dst_i(dst),
        .stall_o(stall), .out_valid_o(out_valid),
        .src1_tag_o(t1), .src1_rdy_o(r1), .src2_tag_o(t2), .src2_rdy_o(r2),
        .dst_tag_o(td), .old_tag_o(told),
        .wb_valid_i(wb_valid), .wb_tag_i(wb_tag),
        .free_valid_i(free_valid), .free_tag_i(free_tag)
    );

    typedef struct packed {
        logic [2:0] s1;
        logic [2:0] s2;
        logic [2:0] d;
        logic       st;
        logic [3:0] e1;
        logic       q1;
        logic [3:0] e2;
        logic       q2;
        logic [3:0] ed;
        logic [3:0] eo;
    } vec_t;

    // Sequence from reset; free list starts 8,9,10,11.
    localparam vec_t VECS [5] = '{
        '{3'd1, 3'd2, 3'd3, 1'b0, 4'd1,  1'b1, 4'd2, 1'b1, 4'd8,  4'd3},
        '{3'd3, 3'd4, 3'd5, 1'b0, 4'd8,  1'b0, 4'd4, 1'b1, 4'd9,  4'd5},
        '{3'd3, 3'd5, 3'd3, 1'b0, 4'd8,  1'b0, 4'd9, 1'b0, 4'd10, 4'd8},
        '{3'd3, 3'd0, 3'd1, 1'b0, 4'd10, 1'b0, 4'd0, 1'b1, 4'd11, 4'd1},
        '{3'd1, 3'd3, 3'd2, 1'b1, 4'd0,  1'b0, 4'd0, 1'b0, 4'd0,  4'd0}
    };

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic put(input logic v, input logic [2:0] a, input logic [2:0] b,
                       input logic [2:0] d);
        in_valid = v; src1 = a; src2 = b; dst = d;
    endtask

    task automatic chk_out(input string req, input logic [3:0] e1, input logic q1,
                           input logic [3:0] e2, input logic q2,
                           input logic [3:0] ed, input logic [3:0] eo);
        chk(req, "out_valid", 8'(out_valid), 8'd1);
        chk(req, "stall", 8'(stall), 8'd0);
        chk(req, "src1_tag", 8'(t1), 8'(e1));
        chk(req, "src1_rdy", 8'(r1), 8'(q1));
        chk(req, "src2_tag", 8'(t2), 8'(e2));
        chk(req, "src2_rdy", 8'(r2), 8'(q2));
        chk(req, "dst_tag", 8'(td), 8'(ed));
        chk(req, "old_tag", 8'(told), 8'(eo));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 / R4: idle after reset
        chk("R9", "out_valid idle", 8'(out_valid), 8'd0);
        chk("R9", "stall idle", 8'(stall), 8'd0);
        chk("R4", "first free tag", 8'(td), 8'd8);

        // R1 R2 R3 R4 R5 R7: vector walk
        foreach (VECS[i]) begin
            @(negedge clk);
            put(1'b1, VECS[i].s1, VECS[i].s2, VECS[i].d);
            #1;
            if (VECS[i].st) begin
                chk("R7", "stall empty", 8'(stall), 8'd1);
                chk("R7", "out_valid empty", 8'(out_valid), 8'd0);
            end else begin
                chk_out("R1 R2 R3", VECS[i].e1, VECS[i].q1, VECS[i].e2,
                        VECS[i].q2, VECS[i].ed, VECS[i].eo);
            end
        end

        // R8: release during an empty-list stall does not lift it
        @(negedge clk);
        put(1'b1, 3'd1, 3'd3, 3'd2);
        free_valid = 1'b1; free_tag = 4'd3;
        #1;
        chk("R8", "stall with release", 8'(stall), 8'd1);

        // R6 R7 R8: released tag 3 handed out; table unchanged by stalls;
        // release 5 and writeback 10 in the same cycle
        @(negedge clk);
        free_tag = 4'd5;
        wb_valid = 1'b1; wb_tag = 4'd10;
        #1;
        chk_out("R6 R7 R8", 4'd11, 1'b0, 4'd10, 1'b0, 4'd3, 4'd2);

        // R5: writeback set 10, allocation cleared 3; R8: tag 5 now at head
        @(negedge clk);
        free_valid = 1'b0; wb_valid = 1'b0;
        put(1'b1, 3'd3, 3'd2, 3'd6);
        #1;
        chk_out("R5 R8", 4'd10, 1'b1, 4'd3, 1'b0, 4'd5, 4'd6);

        // R7: empty again
        @(negedge clk);
        put(1'b1, 3'd0, 3'd0, 3'd0);
        #1;
        chk("R7", "stall second", 8'(stall), 8'd1);
        chk("R7", "out_valid second", 8'(out_valid), 8'd0);

        // R9: idle cycle with a release
        @(negedge clk);
        put(1'b0, 3'd0, 3'd0, 3'd0);
        free_valid = 1'b1; free_tag = 4'd9;
        #1;
        chk("R9", "out_valid idle", 8'(out_valid), 8'd0);
        chk("R9", "stall idle", 8'(stall), 8'd0);

        // R9 R1: mappings held across stall and idle; R6 FIFO tag 9
        @(negedge clk);
        free_valid = 1'b0;
        put(1'b1, 3'd0, 3'd6, 3'd0);
        #1;
        chk_out("R9 R1 R6", 4'd0, 1'b1, 4'd5, 1'b0, 4'd9, 4'd0);

        @(negedge clk);
        put(1'b0, 3'd0, 3'd0, 3'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule